// File: doc/BRIEF.md
# Two-Thread Shared Instruction Fetch Cache

This block is a small direct-mapped instruction-fetch cache that serves two hardware threads through one lookup port. Each thread has its own fetch pointer, which walks sequential word addresses and can be reloaded by a redirect. In every clock cycle a per-cycle arbiter picks one eligible thread. The cache is read with that thread's pointer. A hit returns the word, its address and the thread number on the output one cycle later, and the pointer moves on by one.

Each line records which thread filled it. A lookup counts as a hit only when the stored address tag and the stored thread both match. Storage is not split between the threads, so one thread may fill every line. A miss sends one request to a lower-level memory. The thread then waits until that memory returns the line. The other thread keeps using every lookup slot it is able to use. Returned lines are always written into the cache. A redirect cancels a thread's wait at once.

Top module: `shared_fetch_cache`

## Requirements
- R1: After reset, out_vld and mem_req are low and every line is invalid, so the first lookup of any address misses.
- R2: A lookup that hits raises out_vld on the next cycle with the stored word, the looked-up address and the thread number (0 or 1) on out_tid. The pointer of that thread then moves to address + 1.
- R3: When both threads are eligible in consecutive cycles, the grant alternates between them cycle by cycle.
- R4: A thread is eligible when its fetch_en bit is high, its stall bit is low, it has no miss waiting and its redirect bit is low. When only one thread is eligible, that thread is granted in every cycle.
- R5: A line filled by thread 1 never hits for thread 0 at the same address, and the reverse also holds.
- R6: A lookup that misses raises mem_req for one cycle on the next cycle, carrying the missed address and the requesting thread. A lookup that hits never raises mem_req.
- R7: A thread that missed is not granted again until a fill arrives whose fill_tid equals that thread and whose fill_addr equals its pointer. Meanwhile the other thread is granted in every cycle in which it is eligible.
- R8: A redirect loads the new address into the thread's pointer at the next clock edge and cancels any miss the thread has waiting. The thread is not looked up in the redirect cycle and may be looked up in the following cycle. A fill that later returns for the cancelled miss is still written into the cache.
- R9: Capacity is shared. A single thread can hold all LINES lines at once and then hit on every one of them.
- R10: The line index is the low log2(LINES) bits of the word address, and the rest of the address is the tag. A fill overwrites that line whichever thread owned it before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_en | input | 2 | Per-thread fetch request, bit t for thread t |
| stall | input | 2 | Per-thread stall, bit t for thread t |
| redir_vld | input | 2 | Per-thread pointer redirect strobe |
| redir_pc | input | 2*ADDR_W | Redirect targets, thread t in bits [t*ADDR_W +: ADDR_W] |
| fill_vld | input | 1 | Fill from lower memory is present |
| fill_addr | input | ADDR_W | Word address of the fill |
| fill_tid | input | 1 | Thread that requested the fill |
| fill_data | input | DATA_W | Filled instruction word |
| mem_req | output | 1 | Miss request to lower memory |
| mem_req_addr | output | ADDR_W | Missed word address |
| mem_req_tid | output | 1 | Thread that missed |
| out_vld | output | 1 | Fetched word is valid |
| out_tid | output | 1 | Thread of the fetched word |
| out_addr | output | ADDR_W | Address of the fetched word |
| out_data | output | DATA_W | Fetched instruction word |

## Verification
The hardest case to set up is a redirect that lands while the thread still has a miss waiting. The cancelled fill must then arrive later and be written in without waking the thread. The bench waits until it sees the miss request, redirects in the very next cycle to a line the thread already owns, and checks that the hit appears before the memory model returns the old fill. It then redirects to the cancelled address and checks that this lookup hits with no new request. The window in which one thread waits for a fill is also checked cycle by cycle from the ports: the other thread must produce a word in each of those cycles.

// File: rtl/shared_fetch_pkg.sv
package shared_fetch_pkg;
   localparam int unsigned NTHR = 2;
   typedef enum logic {THR_A = 1'b0, THR_B = 1'b1} thr_e;
endpackage

// File: rtl/sfc_arbiter.sv
module sfc_arbiter
   import shared_fetch_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NTHR-1:0] elig,
   output logic [NTHR-1:0] gnt,
   output thr_e            gnt_thr,
   output logic            gnt_any
);
   thr_e last_q;

   always_comb begin
      case (elig)
         2'b01:   gnt = 2'b01;
         2'b10:   gnt = 2'b10;
         2'b11:   gnt = (last_q == THR_A) ? 2'b10 : 2'b01;
         default: gnt = 2'b00;
      endcase
      gnt_thr = gnt[1] ? THR_B : THR_A;
      gnt_any = |gnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       last_q <= THR_B;
      else if (gnt_any) last_q <= gnt_thr;
   end
endmodule

// File: rtl/sfc_thread_ctx.sv
module sfc_thread_ctx #(
   parameter int unsigned ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redir,
   input  logic [ADDR_W-1:0] redir_pc,
   input  logic              advance,
   input  logic              miss,
   input  logic              fill_match,
   output logic [ADDR_W-1:0] pc,
   output logic              pend
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc   <= RESET_PC;
         pend <= 1'b0;
      end else begin
         if (redir)        pc <= redir_pc;
         else if (advance) pc <= pc + 1'b1;

         if (redir)           pend <= 1'b0;
         else if (miss)       pend <= 1'b1;
         else if (fill_match) pend <= 1'b0;
      end
   end
endmodule

// File: rtl/sfc_line_store.sv
module sfc_line_store
   import shared_fetch_pkg::*;
#(
   parameter int unsigned LINES  = 16,
   parameter int unsigned TAG_W  = 12,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output thr_e              rd_thr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  thr_e              wr_thr,
   input  logic [DATA_W-1:0] wr_data
);
   logic [LINES-1:0] line_vld;
   logic [TAG_W-1:0]  line_tag  [LINES];
   thr_e              line_thr  [LINES];
   logic [DATA_W-1:0] line_data [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic              v_q;
      logic [TAG_W-1:0]  t_q;
      thr_e              o_q;
      logic [DATA_W-1:0] d_q;
      logic              hit_wr;

      assign hit_wr = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n)      v_q <= 1'b0;
         else if (hit_wr) v_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (hit_wr) begin
            t_q <= wr_tag;
            o_q <= wr_thr;
            d_q <= wr_data;
         end
      end

      assign line_vld[i]  = v_q;
      assign line_tag[i]  = t_q;
      assign line_thr[i]  = o_q;
      assign line_data[i] = d_q;
   end

   assign rd_valid = line_vld[rd_idx];
   assign rd_tag   = line_tag[rd_idx];
   assign rd_thr   = line_thr[rd_idx];
   assign rd_data  = line_data[rd_idx];
endmodule

// File: rtl/shared_fetch_cache.sv
module shared_fetch_cache
   import shared_fetch_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LINES    = 16,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             fetch_en,
   input  logic [1:0]             stall,
   input  logic [1:0]             redir_vld,
   input  logic [2*ADDR_W-1:0]    redir_pc,
   input  logic                   fill_vld,
   input  logic [ADDR_W-1:0]      fill_addr,
   input  logic                   fill_tid,
   input  logic [DATA_W-1:0]      fill_data,
   output logic                   mem_req,
   output logic [ADDR_W-1:0]      mem_req_addr,
   output logic                   mem_req_tid,
   output logic                   out_vld,
   output logic                   out_tid,
   output logic [ADDR_W-1:0]      out_addr,
   output logic [DATA_W-1:0]      out_data
);
   localparam int unsigned INDEX_W = $clog2(LINES);
   localparam int unsigned TAG_W   = ADDR_W - INDEX_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (ADDR_W <= INDEX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [NTHR-1:0]   elig;
   logic [NTHR-1:0]   gnt;
   logic [NTHR-1:0]   pend;
   logic [NTHR-1:0]   adv;
   logic [NTHR-1:0]   miss_set;
   logic [NTHR-1:0]   fill_match;
   logic [ADDR_W-1:0] pc_q [NTHR];
   thr_e              gnt_thr;
   logic              gnt_any;
   logic              hit;
   logic [ADDR_W-1:0] look_pc;
   logic              rd_valid;
   logic [TAG_W-1:0]  rd_tag;
   thr_e              rd_thr;
   logic [DATA_W-1:0] rd_data;

   for (genvar t = 0; t < NTHR; t++) begin : g_thr
      assign elig[t]       = fetch_en[t] & ~stall[t] & ~pend[t] & ~redir_vld[t];
      assign adv[t]        = gnt[t] & hit;
      assign miss_set[t]   = gnt[t] & ~hit;
      assign fill_match[t] = fill_vld && (fill_tid == 1'(t)) && (fill_addr == pc_q[t]);

      sfc_thread_ctx #(
         .ADDR_W   (ADDR_W),
         .RESET_PC (RESET_PC)
      ) u_ctx (
         .clk        (clk),
         .rst_n      (rst_n),
         .redir      (redir_vld[t]),
         .redir_pc   (redir_pc[t*ADDR_W +: ADDR_W]),
         .advance    (adv[t]),
         .miss       (miss_set[t]),
         .fill_match (fill_match[t]),
         .pc         (pc_q[t]),
         .pend       (pend[t])
      );
   end

   sfc_arbiter u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .elig    (elig),
      .gnt     (gnt),
      .gnt_thr (gnt_thr),
      .gnt_any (gnt_any)
   );

   assign look_pc = (gnt_thr == THR_B) ? pc_q[1] : pc_q[0];

   sfc_line_store #(
      .LINES  (LINES),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (look_pc[INDEX_W-1:0]),
      .rd_valid (rd_valid),
      .rd_tag   (rd_tag),
      .rd_thr   (rd_thr),
      .rd_data  (rd_data),
      .wr_en    (fill_vld),
      .wr_idx   (fill_addr[INDEX_W-1:0]),
      .wr_tag   (fill_addr[ADDR_W-1:INDEX_W]),
      .wr_thr   (thr_e'(fill_tid)),
      .wr_data  (fill_data)
   );

   assign hit = gnt_any && rd_valid && (rd_tag == look_pc[ADDR_W-1:INDEX_W]) && (rd_thr == gnt_thr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         mem_req <= 1'b0;
      end else begin
         out_vld <= hit;
         mem_req <= gnt_any & ~hit;
      end
   end

   always_ff @(posedge clk) begin
      if (gnt_any) begin
         out_tid      <= gnt_thr;
         out_addr     <= look_pc;
         out_data     <= rd_data;
         mem_req_addr <= look_pc;
         mem_req_tid  <= gnt_thr;
      end
   end
endmodule

// File: rtl/shared_fetch_cache_chk.sv
module shared_fetch_cache_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          elig,
   input logic [1:0]          gnt,
   input logic                hit,
   input logic [1:0]          pend,
   input logic [1:0]          redir_vld,
   input logic [2*ADDR_W-1:0] redir_pc,
   input logic [ADDR_W-1:0]   pc0,
   input logic [ADDR_W-1:0]   pc1,
   input logic                out_vld,
   input logic                out_tid,
   input logic                mem_req
);
   assert_out_follows_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ($past(hit) && (out_tid == $past(gnt[1]))));

   assert_alt_from0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((&elig) && gnt[0]) ##1 (&elig) |-> gnt[1]);

   assert_alt_from1_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((&elig) && gnt[1]) ##1 (&elig) |-> gnt[0]);

   assert_single_elig_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(elig) == 1) |-> (gnt == elig));

   assert_req_only_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($past(|gnt) && !$past(hit)));

   assert_wait_no_grant0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend[0] |-> !gnt[0]);

   assert_wait_no_grant1_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend[1] |-> !gnt[1]);

   assert_redir_load0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld[0] |=> (pc0 == $past(redir_pc[ADDR_W-1:0])) && !pend[0]);

   assert_redir_load1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld[1] |=> (pc1 == $past(redir_pc[2*ADDR_W-1:ADDR_W])) && !pend[1]);
endmodule

bind shared_fetch_cache shared_fetch_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .elig      (elig),
   .gnt       (gnt),
   .hit       (hit),
   .pend      (pend),
   .redir_vld (redir_vld),
   .redir_pc  (redir_pc),
   .pc0       (pc_q[0]),
   .pc1       (pc_q[1]),
   .out_vld   (out_vld),
   .out_tid   (out_tid),
   .mem_req   (mem_req)
);

// File: tb/shared_fetch_cache_tb.sv
module shared_fetch_cache_tb;
   localparam int CLK_P = 10;
   localparam int AW    = 16;
   localparam int DW    = 32;
   localparam int LAT   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    fetch_en = '0;
   logic [1:0]    stall = '0;
   logic [1:0]    redir_vld = '0;
   logic [2*AW-1:0] redir_pc = '0;
   logic          fill_vld = 1'b0;
   logic [AW-1:0] fill_addr = '0;
   logic          fill_tid = 1'b0;
   logic [DW-1:0] fill_data = '0;
   logic          mem_req, mem_req_tid, out_vld, out_tid;
   logic [AW-1:0] mem_req_addr, out_addr;
   logic [DW-1:0] out_data;

   shared_fetch_cache u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .stall(stall),
      .redir_vld(redir_vld), .redir_pc(redir_pc),
      .fill_vld(fill_vld), .fill_addr(fill_addr), .fill_tid(fill_tid), .fill_data(fill_data),
      .mem_req(mem_req), .mem_req_addr(mem_req_addr), .mem_req_tid(mem_req_tid),
      .out_vld(out_vld), .out_tid(out_tid), .out_addr(out_addr), .out_data(out_data)
   );

   always #(CLK_P/2) clk = ~clk;

   int nchk = 0;
   int nerr = 0;
   int cyc = 0;
   int cnt [2] = '{0, 0};
   int reqs = 0;
   int lg_n = 0;
   int lg_cyc [512];
   bit lg_tid [512];
   logic [AW-1:0] expq0 [$];
   logic [AW-1:0] expq1 [$];
   logic [AW-1:0] mq_addr [$];
   bit            mq_tid [$];
   int            mq_due [$];
   bit win_arm = 0;
   bit win_on = 0;
   int win_cnt = 0;

   function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
      return {a ^ 16'hA5C3, a};
   endfunction

   task automatic check(input bit ok, input string what, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // monitor and lower-memory model
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_vld) begin
            logic [AW-1:0] e;
            if ((out_tid ? expq1.size() : expq0.size()) == 0) begin
               check(0, "R2 unexpected output", out_addr, 0);
            end else begin
               e = out_tid ? expq1.pop_front() : expq0.pop_front();
               check(out_addr == e, "R2 output address", out_addr, e);
               check(out_data == word_of(e), "R2 output word", out_data, word_of(e));
            end
            if (lg_n < 512) begin
               lg_cyc[lg_n] = cyc;
               lg_tid[lg_n] = out_tid;
               lg_n++;
            end
            cnt[out_tid]++;
         end
         if (win_on) begin
            win_cnt++;
            check(out_vld && out_tid == 1'b0, "R7 other thread served while one waits", {out_vld, out_tid}, 2'b10);
            if (fill_vld && fill_tid) win_on = 0;
         end
         if (mem_req) begin
            reqs++;
            mq_addr.push_back(mem_req_addr);
            mq_tid.push_back(mem_req_tid);
            mq_due.push_back(cyc + LAT);
            if (win_arm && mem_req_tid) begin
               win_on  = 1;
               win_arm = 0;
            end
         end
         if (mq_due.size() > 0 && mq_due[0] <= cyc) begin
            fill_vld  <= 1'b1;
            fill_addr <= mq_addr[0];
            fill_tid  <= mq_tid[0];
            fill_data <= word_of(mq_addr[0]);
            void'(mq_addr.pop_front());
            void'(mq_tid.pop_front());
            void'(mq_due.pop_front());
         end else begin
            fill_vld <= 1'b0;
         end
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic push_exp(input int t, input logic [AW-1:0] start, input int n);
      for (int i = 0; i < n; i++) begin
         if (t == 0) expq0.push_back(start + AW'(i));
         else        expq1.push_back(start + AW'(i));
      end
   endtask

   task automatic redir(input int t, input logic [AW-1:0] a);
      tick();
      redir_vld[t] = 1'b1;
      redir_pc[t*AW +: AW] = a;
      tick();
      redir_vld[t] = 1'b0;
   endtask

   task automatic run(input int n0, input int n1);
      int tg0 = cnt[0] + n0;
      int tg1 = cnt[1] + n1;
      int guard = 0;
      tick();
      if (n0 > 0) fetch_en[0] = 1'b1;
      if (n1 > 0) fetch_en[1] = 1'b1;
      while (cnt[0] < tg0 || cnt[1] < tg1) begin
         tick();
         if (n0 > 0 && cnt[0] >= tg0) fetch_en[0] = 1'b0;
         if (n1 > 0 && cnt[1] >= tg1) fetch_en[1] = 1'b0;
         guard++;
         if (guard > 2000) begin
            check(0, "R2 run did not complete", cnt[0] + cnt[1], tg0 + tg1);
            break;
         end
      end
      if (n0 > 0) fetch_en[0] = 1'b0;
      if (n1 > 0) fetch_en[1] = 1'b0;
      repeat (2) tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      int r0, l0, c1;
      repeat (5) tick();
      rst_n = 1'b1;
      repeat (2) tick();
      check(out_vld == 1'b0, "R1 out_vld low after reset", out_vld, 0);
      check(mem_req == 1'b0, "R1 mem_req low after reset", mem_req, 0);

      // R1 R6 R9: thread 0 fills the whole cache, thread 1 stalled
      fetch_en[1] = 1'b1;
      stall[1]    = 1'b1;
      redir(0, 16'h0000);
      push_exp(0, 16'h0000, 16);
      r0 = reqs;
      run(16, 0);
      check(reqs - r0 == 16, "R1 cold lines miss, R6 one request per miss", reqs - r0, 16);
      check(cnt[1] == 0, "R4 stalled thread produced nothing", cnt[1], 0);

      redir(0, 16'h0000);
      push_exp(0, 16'h0000, 16);
      r0 = reqs;
      l0 = lg_n;
      run(16, 0);
      check(reqs == r0, "R9 one thread holds all lines, R6 hits send no request", reqs - r0, 0);
      check(lg_cyc[l0 + 15] - lg_cyc[l0] == 15, "R4 sole eligible thread served every cycle",
            lg_cyc[l0 + 15] - lg_cyc[l0], 15);
      fetch_en[1] = 1'b0;
      stall[1]    = 1'b0;

      // R5: thread 1 misses on addresses thread 0 owns
      redir(1, 16'h0000);
      push_exp(1, 16'h0000, 4);
      r0 = reqs;
      run(0, 4);
      check(reqs - r0 == 4, "R5 thread tag blocks hit for other thread", reqs - r0, 4);

      // R3: both hitting, grants alternate
      redir(0, 16'h0004);
      redir(1, 16'h0000);
      push_exp(0, 16'h0004, 4);
      push_exp(1, 16'h0000, 4);
      r0 = reqs;
      l0 = lg_n;
      run(4, 4);
      check(reqs == r0, "R3 all lookups hit", reqs - r0, 0);
      for (int i = 1; i < 8; i++) begin
         check(lg_tid[l0 + i] != lg_tid[l0 + i - 1], "R3 alternating thread", lg_tid[l0 + i], !lg_tid[l0 + i - 1]);
         check(lg_cyc[l0 + i] - lg_cyc[l0 + i - 1] == 1, "R3 back-to-back grants",
               lg_cyc[l0 + i] - lg_cyc[l0 + i - 1], 1);
      end

      // R10: thread 0 refetches lines that thread 1 replaced
      redir(0, 16'h0000);
      push_exp(0, 16'h0000, 4);
      r0 = reqs;
      run(4, 0);
      check(reqs - r0 == 4, "R10 fill replaced other thread's lines", reqs - r0, 4);

      // R7: thread 1 misses at 0x20 (index 0) while thread 0 hits 4..15
      redir(0, 16'h0004);
      redir(1, 16'h0020);
      push_exp(0, 16'h0004, 12);
      push_exp(1, 16'h0020, 1);
      win_arm = 1;
      win_cnt = 0;
      r0 = reqs;
      run(12, 1);
      check(reqs - r0 == 1, "R7 only the waiting thread requested", reqs - r0, 1);
      check(win_cnt >= LAT - 1, "R7 wait window observed", win_cnt, LAT - 1);
      win_arm = 0;

      // R8: redirect while a miss is waiting
      redir(1, 16'h0050);
      r0 = reqs;
      c1 = cnt[1];
      tick();
      fetch_en[1] = 1'b1;
      for (int g = 0; g < 50 && reqs == r0; g++) tick();
      check(reqs == r0 + 1, "R8 miss request seen", reqs - r0, 1);
      redir_vld[1] = 1'b1;
      redir_pc[AW +: AW] = 16'h0020;
      push_exp(1, 16'h0020, 1);
      tick();
      redir_vld[1] = 1'b0;
      tick();
      check(cnt[1] == c1 + 1, "R8 redirect cancels wait, lookup next cycle", cnt[1] - c1, 1);
      fetch_en[1] = 1'b0;
      check(reqs == r0 + 1, "R8 no extra request after redirect", reqs - r0, 1);
      repeat (LAT + 4) tick();
      redir(1, 16'h0050);
      push_exp(1, 16'h0050, 1);
      r0 = reqs;
      run(0, 1);
      check(reqs == r0, "R8 cancelled fill was still written", reqs - r0, 0);

      repeat (4) tick();
      check(expq0.size() == 0, "R2 thread 0 outputs all delivered", expq0.size(), 0);
      check(expq1.size() == 0, "R2 thread 1 outputs all delivered", expq1.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule